// File: doc/BRIEF.md
# Long-Mode Instruction Prefix Decoder

This block sits at the front of a 64-bit mode instruction decode path. It takes one instruction byte per cycle over a valid/ready handshake. It gathers the legacy prefixes and the optional REX prefix that come in front of an instruction, and stops at the first byte that is not a prefix. That byte is the opcode. The block then presents one result record. The record holds the opcode byte, the effective operand and address sizes, the four register-extension bits, the legacy-prefix flags and the number of prefix bytes consumed.

A small state machine controls the block. It has three states:

- `ST_COLLECT` accepts bytes. It moves to `ST_EMIT` on an opcode byte. It moves to `ST_FAULT` when a prefix byte would push the count past the limit.
- `ST_EMIT` holds a normal record until downstream accepts it, then returns to `ST_COLLECT`.
- `ST_FAULT` holds an error record until downstream accepts it, then returns to `ST_COLLECT`.

The accumulated prefix state clears on the handshake that retires a record, and on reset.

Top module: `lm_prefix_decoder`

## Requirements
- R1: A byte whose upper nibble is 0100 (0x40 to 0x4F) is a REX prefix. When it is the last prefix before the opcode, the record shows rex=1, w=bit 3, r=bit 2, x=bit 1 and b=bit 0 of that byte.
- R2: The operand-size code is 2'b00 for 16 bits, 2'b01 for 32 bits and 2'b10 for 64 bits. With no size-changing prefix it is 2'b01.
- R3: A retained REX with W=1 gives code 2'b10, whether or not 0x66 is also present.
- R4: 0x66 with no retained REX.W gives code 2'b00.
- R5: out_asize64 is 1 (64-bit addressing) unless 0x67 is present, in which case it is 0 (32-bit).
- R6: A REX byte followed by any other prefix byte is discarded. The record then shows rex=0 and w=r=x=b=0, but the discarded byte still counts as a prefix.
- R7: 0x26, 0x2E, 0x36, 0x3E, 0x64 and 0x65 set out_seg. 0xF0 sets out_lock, 0xF2 sets out_repne and 0xF3 sets out_repe. None of these changes the size outputs or the REX outputs.
- R8: out_opcode is the first non-prefix byte. out_pfx_cnt is the number of prefix bytes before it, from 0 to 14.
- R9: A 15th prefix byte ends the instruction with an error record (out_err=1, out_pfx_cnt=15, no opcode consumed). The next instruction decodes from a clean state.
- R10: While a record is pending, in_ready is 0, no byte is consumed and the record stays stable. After the out_valid/out_ready handshake, out_valid drops, in_ready rises and the prefix state is empty.
- R11: A synchronous active-high reset drops out_valid, raises in_ready and discards any partly gathered prefixes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte is valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| out_valid | output | 1 | Result record is valid |
| out_ready | input | 1 | Downstream takes the record |
| out_err | output | 1 | Prefix limit exceeded |
| out_opcode | output | 8 | First non-prefix byte |
| out_osize | output | 2 | Operand-size code (00=16, 01=32, 10=64) |
| out_asize64 | output | 1 | 1 = 64-bit address, 0 = 32-bit |
| out_rex | output | 1 | REX retained before opcode |
| out_w | output | 1 | REX.W |
| out_r | output | 1 | Extension of ModRM reg |
| out_x | output | 1 | Extension of SIB index |
| out_b | output | 1 | Extension of r/m, base or opcode register |
| out_seg | output | 1 | Segment override seen |
| out_lock | output | 1 | 0xF0 seen |
| out_repne | output | 1 | 0xF2 seen |
| out_repe | output | 1 | 0xF3 seen |
| out_pfx_cnt | output | 4 | Prefix bytes consumed |

## Verification
The bench sweeps every byte value as a lone leading byte. It also places every REX value both before and after every legacy prefix. A decoder that keeps a REX that was followed by another prefix would show a stale W and wrong extension bits. A decoder that treats 0x66 as dominant would report 16 bits under REX.W.

Prefix runs of 14, 15 and 16 bytes target the off-by-one at the limit. A late or early fault shows up as a wrong count, or as a lost or merged next instruction.

Backpressure is held while a new byte is offered, to expose a decoder that swallows input while its record is pending. A reset in the middle of an instruction exposes leftover prefix state.

// File: rtl/lmpd_pkg.sv
package lmpd_pkg;

    typedef enum logic [1:0] {
        OSZ_16 = 2'b00,
        OSZ_32 = 2'b01,
        OSZ_64 = 2'b10
    } osize_e;

    typedef enum logic [2:0] {
        BC_OPCODE,
        BC_REX,
        BC_OPSZ,
        BC_ADSZ,
        BC_SEG,
        BC_LOCK,
        BC_REPNE,
        BC_REPE
    } bclass_e;

    typedef enum logic [1:0] {
        ST_COLLECT,
        ST_EMIT,
        ST_FAULT
    } dstate_e;

    typedef struct packed {
        logic       opsz;
        logic       adsz;
        logic       seg;
        logic       lock;
        logic       repne;
        logic       repe;
        logic       rex;
        logic [3:0] wrxb;
    } pfx_state_t;

endpackage

// File: rtl/lmpd_classify.sv
module lmpd_classify
    import lmpd_pkg::*;
#(
    parameter logic [3:0] REX_HI = 4'h4
) (
    input  logic [7:0] byte_i,
    output bclass_e    cls_o
);
    always_comb begin
        if (byte_i[7:4] == REX_HI) begin
            cls_o = BC_REX;
        end else begin
            case (byte_i)
                8'h66:                                   cls_o = BC_OPSZ;
                8'h67:                                   cls_o = BC_ADSZ;
                8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: cls_o = BC_SEG;
                8'hF0:                                   cls_o = BC_LOCK;
                8'hF2:                                   cls_o = BC_REPNE;
                8'hF3:                                   cls_o = BC_REPE;
                default:                                 cls_o = BC_OPCODE;
            endcase
        end
    end
endmodule

// File: rtl/lmpd_size_resolve.sv
module lmpd_size_resolve
    import lmpd_pkg::*;
(
    input  logic   rex_w_i,
    input  logic   opsz_i,
    input  logic   adsz_i,
    output osize_e osize_o,
    output logic   asize64_o
);
    always_comb begin
        if (rex_w_i)     osize_o = OSZ_64;
        else if (opsz_i) osize_o = OSZ_16;
        else             osize_o = OSZ_32;
        asize64_o = !adsz_i;
    end
endmodule

// File: rtl/lm_prefix_decoder.sv
module lm_prefix_decoder
    import lmpd_pkg::*;
#(
    parameter int         MAX_PFX = 14,
    parameter logic [3:0] REX_HI  = 4'h4,
    parameter int         CNT_W   = $clog2(MAX_PFX + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_err,
    output logic [7:0]       out_opcode,
    output logic [1:0]       out_osize,
    output logic             out_asize64,
    output logic             out_rex,
    output logic             out_w,
    output logic             out_r,
    output logic             out_x,
    output logic             out_b,
    output logic             out_seg,
    output logic             out_lock,
    output logic             out_repne,
    output logic             out_repe,
    output logic [CNT_W-1:0] out_pfx_cnt
);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_PFX);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    dstate_e          state, nxt;
    bclass_e          cls;
    pfx_state_t       pfx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       op_q;
    logic             accept;
    logic             retire;
    osize_e           osize_w;
    logic             asize64_w;
    logic             keep_rex;

    lmpd_classify #(.REX_HI(REX_HI)) u_cls (
        .byte_i (in_byte),
        .cls_o  (cls)
    );

    assign accept   = in_valid && (state == ST_COLLECT);
    assign retire   = (state != ST_COLLECT) && out_ready;
    assign keep_rex = pfx_q.rex && (state != ST_FAULT);

    lmpd_size_resolve u_size (
        .rex_w_i   (keep_rex && pfx_q.wrxb[3]),
        .opsz_i    (pfx_q.opsz),
        .adsz_i    (pfx_q.adsz),
        .osize_o   (osize_w),
        .asize64_o (asize64_w)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_COLLECT;
        else     state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_COLLECT: begin
                if (accept) begin
                    if (cls == BC_OPCODE)       nxt = ST_EMIT;
                    else if (cnt_q == CNT_LIMIT) nxt = ST_FAULT;
                end
            end
            ST_EMIT:  if (out_ready) nxt = ST_COLLECT;
            ST_FAULT: if (out_ready) nxt = ST_COLLECT;
            default:  nxt = ST_COLLECT;
        endcase
    end

    // prefix accumulator
    always_ff @(posedge clk) begin
        if (rst || retire) begin
            pfx_q <= '0;
            cnt_q <= '0;
            op_q  <= 8'h00;
        end else if (accept) begin
            if (cls == BC_OPCODE) begin
                op_q <= in_byte;
            end else begin
                cnt_q      <= cnt_q + CNT_ONE;
                pfx_q.rex  <= (cls == BC_REX);
                pfx_q.wrxb <= (cls == BC_REX) ? in_byte[3:0] : 4'h0;
                case (cls)
                    BC_OPSZ:  pfx_q.opsz  <= 1'b1;
                    BC_ADSZ:  pfx_q.adsz  <= 1'b1;
                    BC_SEG:   pfx_q.seg   <= 1'b1;
                    BC_LOCK:  pfx_q.lock  <= 1'b1;
                    BC_REPNE: pfx_q.repne <= 1'b1;
                    BC_REPE:  pfx_q.repe  <= 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        in_ready    = (state == ST_COLLECT);
        out_valid   = (state != ST_COLLECT);
        out_err     = (state == ST_FAULT);
        out_opcode  = op_q;
        out_osize   = osize_w;
        out_asize64 = asize64_w;
        out_rex     = keep_rex;
        out_w       = keep_rex && pfx_q.wrxb[3];
        out_r       = keep_rex && pfx_q.wrxb[2];
        out_x       = keep_rex && pfx_q.wrxb[1];
        out_b       = keep_rex && pfx_q.wrxb[0];
        out_seg     = pfx_q.seg;
        out_lock    = pfx_q.lock;
        out_repne   = pfx_q.repne;
        out_repe    = pfx_q.repe;
        out_pfx_cnt = cnt_q;
    end
endmodule

// File: rtl/lmpd_checker.sv
module lmpd_checker #(
    parameter int MAX_PFX = 14,
    parameter int CNT_W   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_err,
    input logic [7:0]       out_opcode,
    input logic [1:0]       out_osize,
    input logic             out_rex,
    input logic             out_w,
    input logic             out_r,
    input logic             out_x,
    input logic             out_b,
    input logic [CNT_W-1:0] out_pfx_cnt
);
    a_r11_reset_idle: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode)
            && $stable(out_pfx_cnt) && $stable(out_osize) && $stable(out_err)));

    a_r10_retire: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (!out_valid && in_ready));

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_err) |-> (out_pfx_cnt <= CNT_W'(MAX_PFX)));

    a_r9_fault_count: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (out_valid && out_pfx_cnt == CNT_W'(MAX_PFX + 1)));

    a_r3_w_wins: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_w) |-> (out_osize == 2'b10));

    a_r6_clean_bits: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_rex) |-> ({out_w, out_r, out_x, out_b} == 4'b0000));
endmodule

bind lm_prefix_decoder lmpd_checker #(.MAX_PFX(MAX_PFX), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_lm_prefix_decoder.sv
module sim_lm_prefix_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready, out_valid, out_err, out_asize64, out_rex;
    logic       out_ready = 1'b0;
    logic [7:0] out_opcode;
    logic [1:0] out_osize;
    logic       out_w, out_r, out_x, out_b, out_seg, out_lock, out_repne, out_repe;
    logic [3:0] out_pfx_cnt;

    int errors = 0;
    int checks = 0;
    logic [7:0] seq [0:19];
    int nseq;

    always #4 clk = ~clk;

    lm_prefix_decoder u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // requirement-level byte classes: 0=opcode 1=rex 2=66 3=67 4=seg 5=F0 6=F2 7=F3
    function automatic int kind(input logic [7:0] v);
        if (v[7:4] == 4'h4) return 1;
        case (v)
            8'h66: return 2;
            8'h67: return 3;
            8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: return 4;
            8'hF0: return 5;
            8'hF2: return 6;
            8'hF3: return 7;
            default: return 0;
        endcase
    endfunction

    task automatic send_byte(input logic [7:0] v);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_byte  = v;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic take_record;
        out_ready = 1'b1;
        @(posedge clk);
        #1 out_ready = 1'b0;
    endtask

    task automatic run_seq(input string tag);
        int cnt = 0;
        logic rex = 0, s66 = 0, s67 = 0, seg = 0, lck = 0, f2 = 0, f3 = 0, err = 0;
        logic [3:0] wrxb = 0;
        logic [7:0] op = 0;
        logic [1:0] osz;
        for (int i = 0; i < nseq; i++) begin
            int k = kind(seq[i]);
            send_byte(seq[i]);
            if (k == 0) begin op = seq[i]; break; end
            cnt++;
            rex  = (k == 1);
            wrxb = (k == 1) ? seq[i][3:0] : 4'h0;
            if (k == 2) s66 = 1;
            if (k == 3) s67 = 1;
            if (k == 4) seg = 1;
            if (k == 5) lck = 1;
            if (k == 6) f2 = 1;
            if (k == 7) f3 = 1;
            if (cnt == 15) begin err = 1; break; end
        end
        @(negedge clk);
        check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        if (err) begin
            check({tag, " err/cnt"}, {27'd0, out_err, out_pfx_cnt}, {27'd0, 1'b1, 4'd15});
        end else begin
            osz = (rex && wrxb[3]) ? 2'b10 : (s66 ? 2'b00 : 2'b01);
            check({tag, " record"},
                {8'd0, out_err, out_opcode, out_osize, out_asize64, out_rex,
                 out_w, out_r, out_x, out_b, out_seg, out_lock, out_repne, out_repe, out_pfx_cnt},
                {8'd0, 1'b0, op, osz, !s67, rex, wrxb, seg, lck, f2, f3, cnt[3:0]});
        end
        take_record();
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] legacy [0:10];
        legacy = '{8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'hF0, 8'hF2, 8'hF3, 8'h66, 8'h67};
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R11 reset in_ready", {31'd0, in_ready}, 32'd1);
        rst = 1'b0;

        // R1 R2 R4 R5 R7 R8: every byte as leading byte
        for (int v = 0; v < 256; v++) begin
            int k = kind(8'(v));
            seq[0] = 8'(v); seq[1] = 8'h90; nseq = 2;
            case (k)
                0: run_seq("R2 R8 plain");
                1: run_seq("R1 rex");
                2: run_seq("R4 opsize");
                3: run_seq("R5 adsize");
                default: run_seq("R7 legacy");
            endcase
        end

        // R1 retained vs R6 discarded REX around each legacy prefix
        for (int r = 0; r < 16; r++) begin
            for (int p = 0; p < 11; p++) begin
                seq[0] = legacy[p]; seq[1] = 8'h40 | 8'(r); seq[2] = 8'h8B; nseq = 3;
                run_seq("R1 rex after legacy");
                seq[0] = 8'h40 | 8'(r); seq[1] = legacy[p]; seq[2] = 8'h8B; nseq = 3;
                run_seq("R6 rex discarded");
            end
        end

        // R3: W beats 0x66
        seq[0] = 8'h66; seq[1] = 8'h48; seq[2] = 8'h89; nseq = 3;
        run_seq("R3 w wins");
        seq[0] = 8'h66; seq[1] = 8'h4F; seq[2] = 8'h01; nseq = 3;
        run_seq("R3 w wins all bits");
        // REX then REX: second retained
        seq[0] = 8'h4F; seq[1] = 8'h41; seq[2] = 8'h50; nseq = 3;
        run_seq("R6 rex then rex");

        // R8 / R9: prefix runs around the limit
        for (int n = 0; n <= 16; n++) begin
            for (int i = 0; i < n; i++) seq[i] = (i % 2 == 0) ? 8'h2E : 8'hF3;
            seq[n] = 8'hC3; nseq = n + 1;
            if (n < 15) run_seq("R8 prefix run");
            else        run_seq("R9 prefix overflow");
            seq[0] = 8'h0F; nseq = 1;
            run_seq("R9 clean after run");
        end

        // R10: backpressure
        send_byte(8'h66);
        send_byte(8'h01);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            in_valid = 1'b1; in_byte = 8'h48;
            check("R10 in_ready low", {31'd0, in_ready}, 32'd0);
            check("R10 held record", {22'd0, out_valid, out_opcode, out_osize},
                  {22'd0, 1'b1, 8'h01, 2'b00});
        end
        @(negedge clk);
        in_valid = 1'b0;
        take_record();
        @(negedge clk);
        check("R10 retired", {30'd0, out_valid, in_ready}, {30'd0, 1'b0, 1'b1});
        seq[0] = 8'h90; nseq = 1;
        run_seq("R10 no stray byte");

        // R11: reset mid-instruction
        send_byte(8'h48);
        send_byte(8'h67);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        seq[0] = 8'h90; nseq = 1;
        run_seq("R11 reset clears prefixes");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule